// File: doc/BRIEF.md
# Sprite animation frame sequencer

This block steps one sprite through a run of animation frames that sit one after another in the sprite's image buffer. Software writes a single control word: a base offset, a frame size in bytes, the index of the last frame, a rate divisor and an auto-restart flag. After that write the block runs with no processor help and no bus traffic. Each vertical-sync tick feeds a rate divider. Every time the divider comes round, the frame index moves on one step. The image offset given to the sprite renderer is the base plus the frame index times the frame size, taken within the 4096-byte buffer.

When the last frame has been shown, one of two things happens. With auto-restart set, the sequence goes back to frame zero and carries on. With it clear, the sequencer stays on the last frame and raises a done flag. From then on it ignores ticks until software writes the control word again. A control write always re-arms the block: the index, the rate counter and the done flag all return to zero.

Top module: `sprite_anim_seq`

## Requirements
- R1: After reset, img_offset, frame_idx and anim_done are all zero, and the latched settings are zero.
- R2: A cycle with cfg_wr high latches every cfg_* input and clears the frame index, the rate counter and anim_done, taking effect at the next clock edge. A vsync_tick in the same cycle is dropped.
- R3: While not done, each vsync_tick moves the rate counter on. The frame steps on every (rate+1)-th tick counted from the last write. Cycles without a tick change no output.
- R4: frame_idx counts upward by one per step and never goes past the latched last-frame value. That value is the number of frames minus one.
- R5: img_offset equals (latched base + frame_idx × latched frame size) mod 4096, with the sum wrapping at the 12-bit buffer size.
- R6: With auto-restart latched as 1, a step taken on the last frame returns frame_idx to 0 and anim_done stays low.
- R7: With auto-restart latched as 0, a step taken on the last frame keeps frame_idx on the last frame and sets anim_done. While done, ticks change nothing until the next write.
- R8: Changes on the cfg_* inputs while cfg_wr is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe; latches settings and re-arms |
| cfg_base | input | 12 | Byte offset of frame 0 in the image buffer |
| cfg_frame_size | input | 12 | Bytes per frame |
| cfg_last_frame | input | 8 | Number of frames minus one |
| cfg_rate | input | 4 | Ticks per frame minus one |
| cfg_auto_restart | input | 1 | 1: loop after the last frame; 0: stop and flag done |
| vsync_tick | input | 1 | One-cycle frame tick |
| img_offset | output | 12 | Current image offset for the renderer |
| frame_idx | output | 8 | Current frame number |
| anim_done | output | 1 | Sequence finished (stop mode only) |

## Verification
Two events can land in the same cycle: a control write and a vsync tick that would otherwise complete a rate period or a frame step. The bench drives both together, on purpose in directed cases and by chance in a long random run. It expects the write to win and the tick to leave no trace. A second collision is the rate divider completing on the last frame. There the step has to either wrap the index or freeze it and set done, depending on the latched restart flag. A behavioural model checks every output on every clock.

// File: rtl/sprite_anim_pkg.sv
package sprite_anim_pkg;

   // What the frame counter does on a given cycle
   typedef enum logic [1:0] {
      ADV_HOLD = 2'd0,
      ADV_NEXT = 2'd1,
      ADV_WRAP = 2'd2,
      ADV_STOP = 2'd3
   } adv_e;

endpackage

// File: rtl/anim_rate_div.sv
module anim_rate_div #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              tick,
   input  logic              hold,
   input  logic [RATE_W-1:0] rate,
   output logic              step
);

   logic [RATE_W-1:0] cnt_q;

   assign step = tick && !clear && !hold && (cnt_q == rate);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (tick && !hold) begin
         cnt_q <= step ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/anim_frame_ctr.sv
module anim_frame_ctr
   import sprite_anim_pkg::*;
#(
   parameter int FCNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [FCNT_W-1:0] last,
   input  logic              auto_restart,
   output logic [FCNT_W-1:0] idx,
   output logic              done,
   output adv_e              adv
);

   always_comb begin
      adv = ADV_HOLD;
      if (step) begin
         if (idx == last) adv = auto_restart ? ADV_WRAP : ADV_STOP;
         else             adv = ADV_NEXT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         done <= 1'b0;
      end else if (clear) begin
         idx  <= '0;
         done <= 1'b0;
      end else begin
         case (adv)
            ADV_NEXT: idx  <= idx + 1'b1;
            ADV_WRAP: idx  <= '0;
            ADV_STOP: done <= 1'b1;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/anim_offset_gen.sv
module anim_offset_gen
   import sprite_anim_pkg::*;
#(
   parameter int OFFS_W   = 12,
   parameter int FCNT_W   = 8,
   parameter bit USE_MULT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  adv_e              adv,
   input  logic [FCNT_W-1:0] idx,
   input  logic [OFFS_W-1:0] base,
   input  logic [OFFS_W-1:0] size,
   output logic [OFFS_W-1:0] offset
);

   localparam int PROD_W = OFFS_W + FCNT_W;

   generate
      if (USE_MULT) begin : g_mult
         logic [PROD_W-1:0] prod;
         logic              unused_mult;
         assign prod        = PROD_W'(idx) * PROD_W'(size);
         assign offset      = base + prod[OFFS_W-1:0];
         assign unused_mult = ^{clk, rst_n, clear, adv, prod[PROD_W-1:OFFS_W]};
      end else begin : g_acc
         // Running sum of frame sizes: one adder, no multiplier
         logic [OFFS_W-1:0] acc_q;
         logic              unused_acc;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (clear) begin
               acc_q <= '0;
            end else begin
               case (adv)
                  ADV_NEXT: acc_q <= acc_q + size;
                  ADV_WRAP: acc_q <= '0;
                  default:  ;
               endcase
            end
         end
         assign offset     = base + acc_q;
         assign unused_acc = ^idx;
      end
   endgenerate

endmodule

// File: rtl/sprite_anim_seq.sv
module sprite_anim_seq
   import sprite_anim_pkg::*;
#(
   parameter int OFFS_W   = 12,
   parameter int FCNT_W   = 8,
   parameter int RATE_W   = 4,
   parameter bit USE_MULT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [OFFS_W-1:0] cfg_base,
   input  logic [OFFS_W-1:0] cfg_frame_size,
   input  logic [FCNT_W-1:0] cfg_last_frame,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic              cfg_auto_restart,
   input  logic              vsync_tick,
   output logic [OFFS_W-1:0] img_offset,
   output logic [FCNT_W-1:0] frame_idx,
   output logic              anim_done
);

   generate
      if (OFFS_W < 4 || OFFS_W > 24) begin : g_bad_offs
         $error("sprite_anim_seq: OFFS_W out of range");
      end
      if (FCNT_W < 1 || FCNT_W > 16) begin : g_bad_fcnt
         $error("sprite_anim_seq: FCNT_W out of range");
      end
      if (RATE_W < 1 || RATE_W > 16) begin : g_bad_rate
         $error("sprite_anim_seq: RATE_W out of range");
      end
   endgenerate

   logic [OFFS_W-1:0] base_q;
   logic [OFFS_W-1:0] size_q;
   logic [FCNT_W-1:0] last_q;
   logic [RATE_W-1:0] rate_q;
   logic              auto_q;
   logic              step;
   adv_e              adv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         last_q <= '0;
         rate_q <= '0;
         auto_q <= 1'b0;
      end else if (cfg_wr) begin
         base_q <= cfg_base;
         size_q <= cfg_frame_size;
         last_q <= cfg_last_frame;
         rate_q <= cfg_rate;
         auto_q <= cfg_auto_restart;
      end
   end

   anim_rate_div #(.RATE_W(RATE_W)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cfg_wr),
      .tick  (vsync_tick),
      .hold  (anim_done),
      .rate  (rate_q),
      .step  (step)
   );

   anim_frame_ctr #(.FCNT_W(FCNT_W)) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (cfg_wr),
      .step         (step),
      .last         (last_q),
      .auto_restart (auto_q),
      .idx          (frame_idx),
      .done         (anim_done),
      .adv          (adv)
   );

   anim_offset_gen #(
      .OFFS_W   (OFFS_W),
      .FCNT_W   (FCNT_W),
      .USE_MULT (USE_MULT)
   ) u_offs (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cfg_wr),
      .adv    (adv),
      .idx    (frame_idx),
      .base   (base_q),
      .size   (size_q),
      .offset (img_offset)
   );

endmodule

// File: rtl/sprite_anim_seq_chk.sv
module sprite_anim_seq_chk #(
   parameter int OFFS_W = 12,
   parameter int FCNT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [OFFS_W-1:0] cfg_base,
   input logic              vsync_tick,
   input logic [OFFS_W-1:0] img_offset,
   input logic [FCNT_W-1:0] frame_idx,
   input logic              anim_done,
   input logic [FCNT_W-1:0] last_q
);

   // R2: a write re-arms the sequence
   a_r2_write_rearms: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (frame_idx == '0) && !anim_done);

   // R5: frame 0 sits at the base offset
   a_r5_offset_at_base: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> img_offset == $past(cfg_base));

   // R3: no tick, no movement
   a_r3_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && !vsync_tick) |=>
         $stable(frame_idx) && $stable(anim_done) && $stable(img_offset));

   // R4: index bounded by the last frame
   a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
      frame_idx <= last_q);

   // R4: index moves by one or wraps to zero
   a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> (frame_idx == $past(frame_idx)) ||
                  (frame_idx == $past(frame_idx) + 1'b1) ||
                  (frame_idx == '0));

   // R7: done freezes the sequence until a write
   a_r7_done_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (anim_done && !cfg_wr) |=> anim_done && $stable(frame_idx));

endmodule

bind sprite_anim_seq sprite_anim_seq_chk #(.OFFS_W(OFFS_W), .FCNT_W(FCNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_base   (cfg_base),
   .vsync_tick (vsync_tick),
   .img_offset (img_offset),
   .frame_idx  (frame_idx),
   .anim_done  (anim_done),
   .last_q     (last_q)
);

// File: tb/sprite_anim_seq_bench.sv
module sprite_anim_seq_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [11:0] cfg_base = '0;
   logic [11:0] cfg_frame_size = '0;
   logic [7:0]  cfg_last_frame = '0;
   logic [3:0]  cfg_rate = '0;
   logic        cfg_auto_restart = 1'b0;
   logic        vsync_tick = 1'b0;
   logic [11:0] img_offset;
   logic [7:0]  frame_idx;
   logic        anim_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   sprite_anim_seq u_sprite_anim_seq (
      .clk              (clk),
      .rst_n            (rst_n),
      .cfg_wr           (cfg_wr),
      .cfg_base         (cfg_base),
      .cfg_frame_size   (cfg_frame_size),
      .cfg_last_frame   (cfg_last_frame),
      .cfg_rate         (cfg_rate),
      .cfg_auto_restart (cfg_auto_restart),
      .vsync_tick       (vsync_tick),
      .img_offset       (img_offset),
      .frame_idx        (frame_idx),
      .anim_done        (anim_done)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;

   // Behavioural reference model
   int m_base, m_size, m_last, m_rate, m_auto;
   int m_idx, m_cnt, m_done;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_base = 0; m_size = 0; m_last = 0; m_rate = 0; m_auto = 0;
         m_idx = 0; m_cnt = 0; m_done = 0;
      end else if (cfg_wr) begin
         m_base = cfg_base; m_size = cfg_frame_size; m_last = cfg_last_frame;
         m_rate = cfg_rate; m_auto = cfg_auto_restart;
         m_idx = 0; m_cnt = 0; m_done = 0;
      end else if (vsync_tick && m_done == 0) begin
         if (m_cnt == m_rate) begin
            m_cnt = 0;
            if (m_idx == m_last) begin
               if (m_auto != 0) m_idx = 0;
               else             m_done = 1;
            end else begin
               m_idx = m_idx + 1;
            end
         end else begin
            m_cnt = m_cnt + 1;
         end
      end
   end

   task automatic chk(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   // Compare away from the active edge, every cycle
   always @(negedge clk) begin
      if (!finished) begin
         chk(cur_req, "img_offset", int'(img_offset), (m_base + m_idx * m_size) % 4096);
         chk(cur_req, "frame_idx", int'(frame_idx), m_idx);
         chk(cur_req, "anim_done", int'(anim_done), m_done);
      end
   end

   task automatic do_write(int base, int size, int last, int rate, bit auto_r, bit tick);
      cfg_base = 12'(base); cfg_frame_size = 12'(size); cfg_last_frame = 8'(last);
      cfg_rate = 4'(rate); cfg_auto_restart = auto_r;
      cfg_wr = 1'b1; vsync_tick = tick;
      @(negedge clk);
      cfg_wr = 1'b0; vsync_tick = 1'b0;
   endtask

   task automatic ticks(int n, int gap);
      for (int i = 0; i < n; i++) begin
         vsync_tick = 1'b1;
         @(negedge clk);
         vsync_tick = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual hung expected finish");
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R6 / R5: looping, one frame per tick
      cur_req = "R6";
      do_write(100, 64, 3, 0, 1'b1, 1'b0);
      ticks(12, 0);
      ticks(5, 1);

      // R3: rate divisor of three ticks per frame, sparse ticks
      cur_req = "R3";
      do_write(8, 40, 4, 2, 1'b1, 1'b0);
      ticks(20, 2);
      repeat (6) @(negedge clk);

      // R7: stop on the last frame and ignore later ticks
      cur_req = "R7";
      do_write(0, 256, 2, 1, 1'b0, 1'b0);
      ticks(15, 0);

      // R8: inputs move without a write
      cur_req = "R8";
      cfg_base = 12'd999; cfg_frame_size = 12'd7; cfg_last_frame = 8'd9;
      cfg_rate = 4'd0; cfg_auto_restart = 1'b1;
      ticks(6, 1);

      // R2: write together with a tick; the tick is dropped
      cur_req = "R2";
      do_write(50, 10, 5, 0, 1'b1, 1'b1);
      ticks(3, 0);
      do_write(60, 12, 5, 1, 1'b1, 1'b0);
      ticks(1, 0);
      do_write(70, 14, 5, 1, 1'b0, 1'b1);
      ticks(14, 0);

      // R5: offset wraps in the 4096-byte buffer
      cur_req = "R5";
      do_write(4000, 1000, 5, 0, 1'b1, 1'b0);
      ticks(14, 0);

      // R4: random mix, writes rare
      cur_req = "R4";
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(0, 49) == 0) begin
            cfg_base = 12'($urandom); cfg_frame_size = 12'($urandom);
            cfg_last_frame = 8'($urandom_range(0, 9)); cfg_rate = 4'($urandom_range(0, 3));
            cfg_auto_restart = 1'($urandom);
            cfg_wr = 1'b1;
         end else begin
            cfg_wr = 1'b0;
         end
         vsync_tick = ($urandom_range(0, 9) < 4);
         @(negedge clk);
      end
      cfg_wr = 1'b0; vsync_tick = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule